// File: doc/BRIEF.md
# Slot Interrupt Router

This block takes interrupt events from PCI devices and routes each one onto the interrupt controller's internal line numbering. An event arrives as a one-cycle strobe. It carries the requesting device's 8-bit device/function number and the interrupt pin it used, coded 0 to 3 for INTA to INTD. The slot number is bits [7:3] of the device/function number. A fixed, slot-dependent swizzle turns the slot and pin into a line number. Lines handled by the controller start at 32, and `line - 32` is the index into two 32-bit configuration masks supplied from outside.

The block uses the edge-mode bit and the polarity bit at that index to drive one interrupt output toward the CPU. With the edge bit set, the output gives a single-cycle pulse. With the edge bit clear, the output goes high and stays high when the polarity bit is set, and goes low when it is clear. A line that falls outside the controller's window leaves the output untouched.

The output is driven by a three-state machine:
- `IRQ_LOW`: output low.
- `IRQ_HELD`: output held high.
- `IRQ_PULSE`: output high for exactly one cycle.

The transitions are:
- **fire-edge**: any state to `IRQ_PULSE`.
- **level-set**: any state to `IRQ_HELD`.
- **level-clear**: any state to `IRQ_LOW`.
- **pulse-expire**: `IRQ_PULSE` to `IRQ_LOW` when no event arrives, or when only an out-of-window event arrives.
- **hold**: `IRQ_LOW` or `IRQ_HELD` stays where it is on an idle cycle or an out-of-window event.

Top module: `slot_irq_router`

## Requirements
- R1: After reset, `cpu_irq` is 0 and `line_num` is 0.
- R2: Both outputs update on the first rising clock edge that samples `evt_valid` high. `line_num` then holds the mapped line for that event.
- R3: For slot 5, the line is 32 + pin.
- R4: Slot 6 always maps to line 36 and slot 7 always maps to line 37, whatever the pin.
- R5: For slots 8 to 12, the line is (slot - 8) + pin + 38.
- R6: Any other slot gives line = pin, untranslated.
- R7: The function bits [2:0] of the device/function number have no effect on the mapped line.
- R8: If bit (line - 32) of `edge_mask` is 1, `cpu_irq` is high for exactly one cycle after the event and then returns to 0 when no further event arrives.
- R9: If the edge bit is 0 and bit (line - 32) of `pol_mask` is 1, `cpu_irq` goes high and stays high until a later event changes it.
- R10: If both the edge bit and the polarity bit are 0, `cpu_irq` goes low.
- R11: An event whose line lies outside 32 to 63 leaves `cpu_irq` unchanged, except that a pulse in progress still ends. `line_num` still takes the untranslated line.
- R12: On cycles without an event, `line_num` holds its value and a held level on `cpu_irq` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | One-cycle strobe marking an interrupt event |
| evt_devfn | input | 8 | Device/function number; bits [7:3] are the slot |
| evt_pin | input | 2 | Interrupt pin, 0..3 for INTA..INTD |
| edge_mask | input | 32 | Per-line edge-mode bits, indexed by line - 32 |
| pol_mask | input | 32 | Per-line polarity bits, indexed by line - 32 |
| line_num | output | 8 | Registered line number of the last event |
| cpu_irq | output | 1 | Interrupt request toward the CPU |

## Verification
A wrong swizzle shows on `line_num` on the cycle after the event. It also often drives `cpu_irq` wrongly, because the wrong mask bit is then selected. A state machine stuck in `IRQ_PULSE`, or one that never leaves it, shows one cycle later as a pulse that is too wide or missing. A wrong window test shows up when an untranslated event disturbs a held level that it should not reach. The directed scenarios check every translated slot and pin combination, and they check each transition while the output is both high and low beforehand.

// File: rtl/sir_pkg.sv
package sir_pkg;

    typedef enum logic [1:0] {
        IRQ_LOW   = 2'd0,
        IRQ_HELD  = 2'd1,
        IRQ_PULSE = 2'd2
    } irq_state_e;

    typedef struct packed {
        logic in_window;
        logic edge_mode;
        logic active_high;
    } line_attr_t;

endpackage

// File: rtl/sir_slot_map.sv
module sir_slot_map #(
    parameter int SLOT_W      = 5,
    parameter int PIN_W       = 2,
    parameter int LINE_W      = 8,
    parameter int LINE_BASE   = 32,
    parameter int SLOT_BRIDGE = 5,
    parameter int SLOT_GFX    = 6,
    parameter int SLOT_NIC    = 7,
    parameter int SLOT_EXP_LO = 8,
    parameter int SLOT_EXP_HI = 12,
    parameter int GFX_OFS     = 4,
    parameter int NIC_OFS     = 5,
    parameter int EXP_OFS     = 6
) (
    input  logic [SLOT_W-1:0] slot,
    input  logic [PIN_W-1:0]  pin,
    output logic [LINE_W-1:0] line
);
    localparam int PIN_COUNT = 1 << PIN_W;

    int slot_i;
    int pin_i;
    int line_i;

    always_comb begin
        slot_i = int'(slot);
        pin_i  = int'(pin);
        if (slot_i == SLOT_BRIDGE) begin
            line_i = LINE_BASE + (pin_i % PIN_COUNT);
        end else if (slot_i == SLOT_GFX) begin
            line_i = LINE_BASE + GFX_OFS;
        end else if (slot_i == SLOT_NIC) begin
            line_i = LINE_BASE + NIC_OFS;
        end else if (slot_i >= SLOT_EXP_LO && slot_i <= SLOT_EXP_HI) begin
            line_i = LINE_BASE + EXP_OFS + (slot_i - SLOT_EXP_LO) + pin_i;
        end else begin
            line_i = pin_i;
        end
        line = LINE_W'(line_i);
    end

endmodule

// File: rtl/sir_line_select.sv
module sir_line_select #(
    parameter int LINE_W    = 8,
    parameter int LINE_BASE = 32,
    parameter int NUM_LINES = 32
) (
    input  logic [LINE_W-1:0]    line,
    input  logic [NUM_LINES-1:0] edge_mask,
    input  logic [NUM_LINES-1:0] pol_mask,
    output sir_pkg::line_attr_t  attr
);
    localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    int               rel;
    logic [IDX_W-1:0] idx;

    always_comb begin
        rel            = int'(line) - LINE_BASE;
        attr.in_window = (rel >= 0) && (rel < NUM_LINES);
        idx            = attr.in_window ? IDX_W'(rel) : '0;
        attr.edge_mode   = attr.in_window & edge_mask[idx];
        attr.active_high = attr.in_window & pol_mask[idx];
    end

endmodule

// File: rtl/sir_irq_fsm.sv
module sir_irq_fsm (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ev,
    input  sir_pkg::line_attr_t attr,
    output logic                cpu_irq
);
    import sir_pkg::*;

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (ev && attr.in_window) begin
            if (attr.edge_mode) begin
                state_d = IRQ_PULSE;
            end else if (attr.active_high) begin
                state_d = IRQ_HELD;
            end else begin
                state_d = IRQ_LOW;
            end
        end else begin
            unique case (state_q)
                IRQ_PULSE: state_d = IRQ_LOW;
                IRQ_HELD:  state_d = IRQ_HELD;
                IRQ_LOW:   state_d = IRQ_LOW;
                default:   state_d = IRQ_LOW;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_LOW:   cpu_irq = 1'b0;
            IRQ_HELD:  cpu_irq = 1'b1;
            IRQ_PULSE: cpu_irq = 1'b1;
            default:   cpu_irq = 1'b0;
        endcase
    end

    AST_EDGE_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && attr.in_window && attr.edge_mode) |=> cpu_irq); // R8
    AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_PULSE && !ev) |=> !cpu_irq); // R8
    AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && attr.in_window && !attr.edge_mode && attr.active_high) |=> cpu_irq); // R9
    AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && attr.in_window && !attr.edge_mode && !attr.active_high) |=> !cpu_irq); // R10
    AST_OUTSIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !attr.in_window && state_q != IRQ_PULSE) |=> $stable(cpu_irq)); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev && state_q != IRQ_PULSE) |=> $stable(cpu_irq)); // R12

endmodule

// File: rtl/slot_irq_router.sv
module slot_irq_router #(
    parameter int DEVFN_W   = 8,
    parameter int FUNC_W    = 3,
    parameter int PIN_W     = 2,
    parameter int LINE_W    = 8,
    parameter int LINE_BASE = 32,
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_valid,
    input  logic [DEVFN_W-1:0]   evt_devfn,
    input  logic [PIN_W-1:0]     evt_pin,
    input  logic [NUM_LINES-1:0] edge_mask,
    input  logic [NUM_LINES-1:0] pol_mask,
    output logic [LINE_W-1:0]    line_num,
    output logic                 cpu_irq
);
    localparam int SLOT_W = DEVFN_W - FUNC_W;

    logic [SLOT_W-1:0]   slot;
    logic [LINE_W-1:0]   mapped_line;
    sir_pkg::line_attr_t attr;
    logic                func_unused;

    assign slot        = evt_devfn[DEVFN_W-1:FUNC_W];
    assign func_unused = ^evt_devfn[FUNC_W-1:0];

    sir_slot_map #(
        .SLOT_W    (SLOT_W),
        .PIN_W     (PIN_W),
        .LINE_W    (LINE_W),
        .LINE_BASE (LINE_BASE)
    ) u_map (
        .slot (slot),
        .pin  (evt_pin),
        .line (mapped_line)
    );

    sir_line_select #(
        .LINE_W    (LINE_W),
        .LINE_BASE (LINE_BASE),
        .NUM_LINES (NUM_LINES)
    ) u_sel (
        .line      (mapped_line),
        .edge_mask (edge_mask),
        .pol_mask  (pol_mask),
        .attr      (attr)
    );

    sir_irq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (evt_valid),
        .attr    (attr),
        .cpu_irq (cpu_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_num <= '0;
        end else if (evt_valid) begin
            line_num <= mapped_line;
        end
    end

    AST_LINE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> (line_num == $past(mapped_line))); // R2
    AST_NIC_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && int'(slot) == 7) |=> (line_num == LINE_W'(LINE_BASE + 5))); // R4
    AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=> $stable(line_num)); // R12

endmodule

// File: tb/sim_slot_irq_router.sv
`timescale 1ns/1ps
module sim_slot_irq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [7:0]  evt_devfn = '0;
    logic [1:0]  evt_pin = '0;
    logic [31:0] edge_mask = '0;
    logic [31:0] pol_mask = '0;
    logic [7:0]  line_num;
    logic        cpu_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    slot_irq_router u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_devfn (evt_devfn),
        .evt_pin   (evt_pin),
        .edge_mask (edge_mask),
        .pol_mask  (pol_mask),
        .line_num  (line_num),
        .cpu_irq   (cpu_irq)
    );

    function automatic int exp_line(int slot, int pin);
        if (slot == 5) return 32 + pin;
        if (slot == 6) return 36;
        if (slot == 7) return 37;
        if (slot >= 8 && slot <= 12) return slot - 8 + pin + 38;
        return pin;
    endfunction

    task automatic chk(int actual, int expected, string req);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // one event; on return outputs reflect it (sampled at the negedge after capture)
    task automatic fire(int slot, int func, int pin);
        @(negedge clk);
        evt_devfn = 8'((slot << 3) | func);
        evt_pin   = 2'(pin);
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk(int'(cpu_irq), 0, "R1 irq");
        chk(int'(line_num), 0, "R1 line");
    endtask

    task automatic t_bridge_slot();
        edge_mask = '0;
        pol_mask  = '1;
        for (int p = 0; p < 4; p++) begin
            fire(5, 0, p);
            chk(int'(line_num), 32 + p, "R3 line");
            chk(int'(cpu_irq), 1, "R2 irq same cycle");
        end
    endtask

    task automatic t_fixed_slots();
        for (int p = 0; p < 4; p++) begin
            fire(6, 0, p);
            chk(int'(line_num), 36, "R4 slot6");
            fire(7, 0, p);
            chk(int'(line_num), 37, "R4 slot7");
        end
    endtask

    task automatic t_expansion();
        for (int s = 8; s <= 12; s++) begin
            for (int p = 0; p < 4; p++) begin
                fire(s, 0, p);
                chk(int'(line_num), exp_line(s, p), "R5 expansion");
            end
        end
    endtask

    task automatic t_func_bits();
        fire(9, 7, 1);
        chk(int'(line_num), 40, "R7 func bits");
        fire(5, 5, 3);
        chk(int'(line_num), 35, "R7 func bits");
    endtask

    task automatic t_passthrough();
        edge_mask = '0;
        pol_mask  = 32'h0000_0010;
        fire(6, 0, 0);
        chk(int'(cpu_irq), 1, "R9 setup high");
        fire(3, 0, 2);
        chk(int'(line_num), 2, "R6 untranslated");
        chk(int'(cpu_irq), 1, "R11 high kept");
        pol_mask = '0;
        fire(6, 0, 0);
        chk(int'(cpu_irq), 0, "R10 low");
        pol_mask = '1;
        fire(0, 0, 3);
        chk(int'(line_num), 3, "R6 untranslated");
        chk(int'(cpu_irq), 0, "R11 low kept");
        fire(31, 0, 1);
        chk(int'(line_num), 1, "R6 slot31");
    endtask

    task automatic t_edge_pulse();
        edge_mask = 32'h0000_0020;
        pol_mask  = '0;
        fire(7, 0, 2);
        chk(int'(cpu_irq), 1, "R8 pulse high");
        @(negedge clk);
        chk(int'(cpu_irq), 0, "R8 pulse ends");
        @(negedge clk);
        chk(int'(cpu_irq), 0, "R8 stays low");
        // pulse followed immediately by an out-of-window event still ends
        fire(7, 0, 0);
        chk(int'(cpu_irq), 1, "R8 pulse again");
        fire(2, 0, 0);
        chk(int'(cpu_irq), 0, "R11 pulse ends on outside event");
    endtask

    task automatic t_level_masks();
        edge_mask = 32'h0000_0400;
        pol_mask  = 32'h0000_0800;
        fire(12, 0, 1);
        chk(int'(cpu_irq), 1, "R9 level high line43");
        fire(12, 0, 0);
        chk(int'(cpu_irq), 1, "R8 edge line42 high");
        @(negedge clk);
        chk(int'(cpu_irq), 0, "R8 edge from held ends low");
        fire(12, 0, 1);
        chk(int'(cpu_irq), 1, "R9 level high again");
        pol_mask = '0;
        fire(12, 0, 1);
        chk(int'(cpu_irq), 0, "R10 level low");
    endtask

    task automatic t_hold();
        edge_mask = '0;
        pol_mask  = '1;
        fire(8, 0, 3);
        chk(int'(line_num), 41, "R5 line41");
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk(int'(line_num), 41, "R12 line hold");
        chk(int'(cpu_irq), 1, "R12 level hold");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bridge_slot();
        t_fixed_slots();
        t_expansion();
        t_func_bits();
        t_passthrough();
        t_edge_pulse();
        t_level_masks();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule